// File: doc/BRIEF.md
# Privilege-aware count filter

This block decides, for every performance counter in a bank, whether that counter may advance in the current execution context. Each event counter and the single cycle counter supplies a 32-bit filter word, and every filter word uses the same layout. The block reads that word against the current privilege level (0 to 3) and the current security state. For each counter it produces one count-permit bit. For each event counter it also produces the 16-bit event selector taken from the low bits of its word.

Several filter bits only mean something when compared with another bit. The non-secure kernel bit and the monitor bit permit counting when they equal the kernel-exclude bit. The secure-hypervisor bit permits counting when it differs from the hypervisor-include bit. The permit logic therefore compares bits and does not just select one of them. Presence parameters describe which privilege levels and which features the system implements. A filter bit that belongs to an absent level or feature reads as zero. An output stage is either one register or a direct path, chosen by a parameter, so the block can sit in a registered counter pipeline or feed counters in the same cycle.

Top module: `priv_count_filter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all permits and all event selectors are 0 (default registered output stage).
- R2: At level 0 a counter is permitted exactly when its filter bit 30 (user exclude) is 0. When the user-exclude feature is absent, level 0 always counts.
- R3: At secure level 1 a counter is permitted exactly when filter bit 31 (kernel exclude) is 0. Bit 29 has no effect there.
- R4: At non-secure level 1 a counter is permitted exactly when filter bit 29 equals filter bit 31.
- R5: At non-secure level 2 a counter is permitted exactly when filter bit 27 (hypervisor include) is 1.
- R6: At secure level 2 a counter is permitted exactly when filter bit 24 differs from filter bit 27.
- R7: At level 3 a counter is permitted exactly when filter bit 26 equals filter bit 31.
- R8: Event selector n equals bits [15:0] of filter word n when the selector extension is present. Filter bits [31:16] never change a selector.
- R9: The cycle-counter permit follows R2 to R7 using its own filter word. That word uses the same bit layout and is independent of the event words.
- R10: With the default output stage, the outputs show the inputs sampled at the previous rising clock edge, so a change in an input is not visible before the next edge.
- R11: Each event counter's permit depends only on its own filter word.
- R12: When a presence parameter is cleared, the matching bit reads as 0: bit 29 without level 3 (and level 3 never counts), bit 27 without level 2, bit 24 without secure level 2, and selector bits [15:10] without the extension.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| cur_secure | input | 1 | 1 = secure state, 0 = non-secure state |
| evt_filt | input | NUM_EVT*32 | Filter words of the event counters; counter n occupies bits [32n+31:32n] |
| cyc_filt | input | 32 | Filter word of the cycle counter |
| evt_permit | output | NUM_EVT | Count permit per event counter; bit n belongs to counter n |
| cyc_permit | output | 1 | Count permit of the cycle counter |
| evt_sel | output | NUM_EVT*16 | Event selector per event counter; counter n occupies bits [16n+15:16n] |

## Verification
On every cycle the assertions check the following on the cycle counter: the cleared outputs after reset, the level-0 user-exclude rule, the kernel-exclude rule at secure level 1, and the hypervisor-include rule at non-secure level 2. They also check that outputs hold still when the inputs have held still for a cycle. The bench's scenarios are needed for the remaining rules. These are the comparison rules (non-secure level 1, secure level 2 and level 3), the independence of individual counters, the selector extraction, and the one-cycle latency observed before the clock edge. Only the bench covers the reserved-bit behaviour, using a second instance built with the presence parameters cleared.

// File: rtl/pfilt_pkg.sv
package pfilt_pkg;
  // filter word geometry; positions are decoded by the permit logic
  localparam int FILT_W     = 32;
  localparam int EVT_W      = 16;
  localparam int EVT_BASE_W = 10;
  localparam int B_KEXCL    = 31;  // kernel exclude
  localparam int B_UEXCL    = 30;  // user exclude
  localparam int B_NSKRN    = 29;  // non-secure kernel, compared with kernel exclude
  localparam int B_HINC     = 27;  // hypervisor include
  localparam int B_MON      = 26;  // monitor, compared with kernel exclude
  localparam int B_SHYP     = 24;  // secure hypervisor, compared with hypervisor include

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } lvl_e;

  typedef struct packed {
    logic             kexcl;
    logic             uexcl;
    logic             nskrn;
    logic             hinc;
    logic             mon;
    logic             shyp;
    logic [EVT_W-1:0] evt;
  } filt_fields_t;
endpackage

// File: rtl/pfilt_decode.sv
module pfilt_decode
  import pfilt_pkg::*;
#(
  parameter bit HAS_LVL2      = 1'b1,
  parameter bit HAS_LVL3      = 1'b1,
  parameter bit HAS_SEC_LVL2  = 1'b1,
  parameter bit HAS_EVT_EXT   = 1'b1,
  parameter bit HAS_USER_EXCL = 1'b1
) (
  input  logic [FILT_W-1:0] word,
  output filt_fields_t      fields
);
  localparam int EXT_W = EVT_W - EVT_BASE_W;

  logic [EXT_W-1:0] ext_bits;
  logic             unused_bits;

  generate
    if (HAS_EVT_EXT) begin : g_ext
      assign ext_bits = word[EVT_W-1:EVT_BASE_W];
    end else begin : g_noext
      assign ext_bits = '0;
    end
  endgenerate

  always_comb begin
    fields.kexcl = word[B_KEXCL];
    fields.uexcl = HAS_USER_EXCL ? word[B_UEXCL] : 1'b0;
    fields.nskrn = HAS_LVL3      ? word[B_NSKRN] : 1'b0;
    fields.hinc  = HAS_LVL2      ? word[B_HINC]  : 1'b0;
    fields.mon   = word[B_MON];
    fields.shyp  = HAS_SEC_LVL2  ? word[B_SHYP]  : 1'b0;
    fields.evt   = {ext_bits, word[EVT_BASE_W-1:0]};
  end

  // bits with no meaning to this block, plus ones a parameter may mask
  assign unused_bits = ^{word[B_SHYP-1:EVT_W], word[B_MON-1], word[B_HINC+1],
                         word[EVT_W-1:EVT_BASE_W]};
endmodule

// File: rtl/pfilt_permit.sv
module pfilt_permit
  import pfilt_pkg::*;
#(
  parameter bit HAS_LVL3 = 1'b1
) (
  input  logic [1:0]   lvl,
  input  logic         secure,
  input  filt_fields_t fields,
  output logic         permit
);
  always_comb begin
    unique case (lvl_e'(lvl))
      LVL_USER:   permit = ~fields.uexcl;
      LVL_KERNEL: permit = secure ? ~fields.kexcl
                                  : (fields.nskrn == fields.kexcl);
      LVL_HYP:    permit = secure ? (fields.shyp != fields.hinc)
                                  : fields.hinc;
      LVL_MON:    permit = HAS_LVL3 && (fields.mon == fields.kexcl);
      default:    permit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pfilt_out_stage.sv
module pfilt_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_pass
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/priv_count_filter.sv
module priv_count_filter
  import pfilt_pkg::*;
#(
  parameter int NUM_EVT       = 4,
  parameter bit HAS_LVL2      = 1'b1,
  parameter bit HAS_LVL3      = 1'b1,
  parameter bit HAS_SEC_LVL2  = 1'b1,
  parameter bit HAS_EVT_EXT   = 1'b1,
  parameter bit HAS_USER_EXCL = 1'b1,
  parameter bit REG_OUT       = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                cur_lvl,
  input  logic                      cur_secure,
  input  logic [NUM_EVT*FILT_W-1:0] evt_filt,
  input  logic [FILT_W-1:0]         cyc_filt,
  output logic [NUM_EVT-1:0]        evt_permit,
  output logic                      cyc_permit,
  output logic [NUM_EVT*EVT_W-1:0]  evt_sel
);
  localparam int OUT_W = NUM_EVT * EVT_W + NUM_EVT + 1;

  logic [NUM_EVT-1:0]       permit_d;
  logic [NUM_EVT*EVT_W-1:0] sel_d;
  logic                     cyc_permit_d;
  filt_fields_t             cyc_fields;
  logic [OUT_W-1:0]         stage_q;

  generate
    for (genvar n = 0; n < NUM_EVT; n++) begin : g_evt
      filt_fields_t f;

      pfilt_decode #(
        .HAS_LVL2(HAS_LVL2), .HAS_LVL3(HAS_LVL3), .HAS_SEC_LVL2(HAS_SEC_LVL2),
        .HAS_EVT_EXT(HAS_EVT_EXT), .HAS_USER_EXCL(HAS_USER_EXCL)
      ) u_dec (
        .word   (evt_filt[n*FILT_W +: FILT_W]),
        .fields (f)
      );

      pfilt_permit #(.HAS_LVL3(HAS_LVL3)) u_perm (
        .lvl    (cur_lvl),
        .secure (cur_secure),
        .fields (f),
        .permit (permit_d[n])
      );

      assign sel_d[n*EVT_W +: EVT_W] = f.evt;
    end
  endgenerate

  pfilt_decode #(
    .HAS_LVL2(HAS_LVL2), .HAS_LVL3(HAS_LVL3), .HAS_SEC_LVL2(HAS_SEC_LVL2),
    .HAS_EVT_EXT(HAS_EVT_EXT), .HAS_USER_EXCL(HAS_USER_EXCL)
  ) u_cyc_dec (
    .word   (cyc_filt),
    .fields (cyc_fields)
  );

  pfilt_permit #(.HAS_LVL3(HAS_LVL3)) u_cyc_perm (
    .lvl    (cur_lvl),
    .secure (cur_secure),
    .fields (cyc_fields),
    .permit (cyc_permit_d)
  );

  // the cycle counter has no selector output
  logic unused_cyc_evt;
  assign unused_cyc_evt = ^cyc_fields.evt;

  pfilt_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
    .clk (clk),
    .rst (rst),
    .d   ({sel_d, permit_d, cyc_permit_d}),
    .q   (stage_q)
  );

  assign {evt_sel, evt_permit, cyc_permit} = stage_q;
endmodule

// File: rtl/pfilt_chk.sv
module pfilt_chk
  import pfilt_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic                      clk,
  input logic                      rst,
  input logic [1:0]                cur_lvl,
  input logic                      cur_secure,
  input logic [NUM_EVT*FILT_W-1:0] evt_filt,
  input logic [FILT_W-1:0]         cyc_filt,
  input logic [NUM_EVT-1:0]        evt_permit,
  input logic                      cyc_permit,
  input logic [NUM_EVT*EVT_W-1:0]  evt_sel
);
  logic prev_ok;

  always_ff @(posedge clk) prev_ok <= !rst;

  generate
    if (REG_OUT) begin : g_chk
      // R1
      reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !prev_ok |-> (evt_permit == '0 && !cyc_permit && evt_sel == '0));

      // R2
      user_count_chk: assert property (@(posedge clk) disable iff (rst)
        prev_ok && $past(cur_lvl == 2'd0 && !cyc_filt[B_UEXCL]) |-> cyc_permit);

      // R3
      sec_kernel_excl_chk: assert property (@(posedge clk) disable iff (rst)
        prev_ok && $past(cur_lvl == 2'd1 && cur_secure && cyc_filt[B_KEXCL])
        |-> !cyc_permit);

      // R5
      ns_hyp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        prev_ok && $past(cur_lvl == 2'd2 && !cur_secure && !cyc_filt[B_HINC])
        |-> !cyc_permit);

      // R10
      hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        prev_ok && $stable(cur_lvl) && $stable(cur_secure) &&
        $stable(evt_filt) && $stable(cyc_filt)
        |=> $stable(evt_permit) && $stable(cyc_permit) && $stable(evt_sel));
    end
  endgenerate
endmodule

bind priv_count_filter pfilt_chk #(.NUM_EVT(NUM_EVT), .REG_OUT(REG_OUT)) u_pfilt_chk (
  .clk        (clk),
  .rst        (rst),
  .cur_lvl    (cur_lvl),
  .cur_secure (cur_secure),
  .evt_filt   (evt_filt),
  .cyc_filt   (cyc_filt),
  .evt_permit (evt_permit),
  .cyc_permit (cyc_permit),
  .evt_sel    (evt_sel)
);

// File: tb/test_priv_count_filter.sv
module test_priv_count_filter;
  localparam int CLK_P = 10;
  localparam int NE    = 4;
  localparam int NV    = 22;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       lvl = 2'd0;
  logic             sec = 1'b0;
  logic [NE*32-1:0] ef  = '0;
  logic [31:0]      cf  = '0;
  logic [NE-1:0]    ep, ep_m;
  logic             cp, cp_m;
  logic [NE*16-1:0] es, es_m;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  priv_count_filter #(.NUM_EVT(NE)) i_priv_count_filter (
    .clk(clk), .rst(rst), .cur_lvl(lvl), .cur_secure(sec),
    .evt_filt(ef), .cyc_filt(cf),
    .evt_permit(ep), .cyc_permit(cp), .evt_sel(es)
  );

  priv_count_filter #(
    .NUM_EVT(NE), .HAS_LVL2(1'b0), .HAS_LVL3(1'b0), .HAS_SEC_LVL2(1'b0),
    .HAS_EVT_EXT(1'b0), .HAS_USER_EXCL(1'b0)
  ) i_priv_count_filter_min (
    .clk(clk), .rst(rst), .cur_lvl(lvl), .cur_secure(sec),
    .evt_filt(ef), .cyc_filt(cf),
    .evt_permit(ep_m), .cyc_permit(cp_m), .evt_sel(es_m)
  );

  // vector: {level[1:0], secure, expected permit, filter word[31:0]}
  // bits: 31 kernel excl, 30 user excl, 29 ns kernel, 27 hyp incl, 26 monitor, 24 secure hyp
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b1, 32'h0000_0000},  // R2
    {2'd0, 1'b0, 1'b0, 32'h4000_0000},  // R2 user excluded
    {2'd0, 1'b1, 1'b1, 32'h8000_0000},  // R2 kernel bit ignored at level 0
    {2'd1, 1'b1, 1'b1, 32'h0000_0000},  // R3
    {2'd1, 1'b1, 1'b0, 32'h8000_0000},  // R3
    {2'd1, 1'b1, 1'b1, 32'h2000_0000},  // R3 ns kernel bit ignored
    {2'd1, 1'b0, 1'b1, 32'h0000_0000},  // R4 equal
    {2'd1, 1'b0, 1'b0, 32'h8000_0000},  // R4 differ
    {2'd1, 1'b0, 1'b0, 32'h2000_0000},  // R4 differ
    {2'd1, 1'b0, 1'b1, 32'hA000_0000},  // R4 equal, both set
    {2'd2, 1'b0, 1'b0, 32'h0000_0000},  // R5
    {2'd2, 1'b0, 1'b1, 32'h0800_0000},  // R5
    {2'd2, 1'b0, 1'b0, 32'h0100_0000},  // R5 secure hyp bit ignored
    {2'd2, 1'b1, 1'b0, 32'h0000_0000},  // R6 equal
    {2'd2, 1'b1, 1'b1, 32'h0100_0000},  // R6 differ
    {2'd2, 1'b1, 1'b1, 32'h0800_0000},  // R6 differ
    {2'd2, 1'b1, 1'b0, 32'h0900_0000},  // R6 equal, both set
    {2'd3, 1'b1, 1'b1, 32'h0000_0000},  // R7 equal
    {2'd3, 1'b1, 1'b0, 32'h8000_0000},  // R7 differ
    {2'd3, 1'b1, 1'b0, 32'h0400_0000},  // R7 differ
    {2'd3, 1'b1, 1'b1, 32'h8400_0000},  // R7 equal, both set
    {2'd3, 1'b0, 1'b1, 32'h0000_FFFF}   // R7 selector bits ignored by permit
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] l, input logic s,
                       input logic [NE*32-1:0] e, input logic [31:0] c);
    @(negedge clk);
    lvl = l; sec = s; ef = e; cf = c;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    logic [NE*16-1:0] exp_sel;
    logic [NE*16-1:0] exp_sel_m;
    logic [NE*32-1:0] wv;

    // R1: inputs would permit everything, reset holds outputs low
    repeat (3) @(posedge clk);
    #1;
    check("R1 permits in reset", {59'd0, ep, cp}, 64'd0);
    check("R1 selectors in reset", {48'd0, es}, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 first cycle after reset", {59'd0, ep, cp}, 64'd0);

    // R2..R7, R9: the vector table, same word for every counter and the cycle counter
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][35:34], VEC[v][33], {NE{VEC[v][31:0]}}, VEC[v][31:0]);
      check($sformatf("R2-7/R9 vector %0d", v), {59'd0, ep, cp},
            {59'd0, {(NE+1){VEC[v][32]}}});
    end

    // R10: change visible only after the next rising edge
    drive(2'd2, 1'b0, '0, 32'h0);
    @(negedge clk);
    ef = {NE{32'h0800_0000}};
    cf = 32'h0800_0000;
    #1;
    check("R10 no change before edge", {59'd0, ep, cp}, 64'd0);
    @(posedge clk);
    #1;
    check("R10 change after edge", {59'd0, ep, cp}, {59'd0, 5'b11111});

    // R11: only counter 0 excludes kernel at secure level 1
    drive(2'd1, 1'b1, {{(NE-1){32'h0}}, 32'h8000_0000}, 32'h0);
    check("R11 per-counter permit", {59'd0, ep, cp}, {59'd0, 4'b1110, 1'b1});

    // R9: cycle word differs from event words at level 3
    drive(2'd3, 1'b0, '0, 32'h0400_0000);
    check("R9 cycle own word", {59'd0, ep, cp}, {59'd0, 4'b1111, 1'b0});

    // R8, R12: selectors with noise in bits [31:16]
    wv = '0;
    exp_sel = '0;
    exp_sel_m = '0;
    for (int i = 0; i < NE; i++) begin
      logic [15:0] s;
      s = 16'hC3A5 + 16'(i) * 16'h1111;
      wv[i*32 +: 32] = {16'h0B0F, s};
      exp_sel[i*16 +: 16] = s;
      exp_sel_m[i*16 +: 16] = s & 16'h03FF;
    end
    drive(2'd0, 1'b0, wv, 32'h0);
    check("R8 selectors", {48'd0, es}, {48'd0, exp_sel});
    check("R12 selector extension absent", {48'd0, es_m}, {48'd0, exp_sel_m});

    // R12: presence parameters cleared
    drive(2'd1, 1'b0, {NE{32'h2000_0000}}, 32'h2000_0000);
    check("R12 ns kernel bit reserved", {59'd0, ep_m, cp_m}, {59'd0, 5'b11111});
    check("R4 full instance same word", {59'd0, ep, cp}, 64'd0);
    drive(2'd2, 1'b0, {NE{32'h0800_0000}}, 32'h0800_0000);
    check("R12 hyp include reserved", {59'd0, ep_m, cp_m}, 64'd0);
    drive(2'd2, 1'b1, {NE{32'h0100_0000}}, 32'h0100_0000);
    check("R12 secure hyp reserved", {59'd0, ep_m, cp_m}, 64'd0);
    drive(2'd3, 1'b1, '0, 32'h0);
    check("R12 level 3 absent", {59'd0, ep_m, cp_m}, 64'd0);
    drive(2'd0, 1'b0, {NE{32'h4000_0000}}, 32'h4000_0000);
    check("R12 R2 user exclude absent", {59'd0, ep_m, cp_m}, {59'd0, 5'b11111});
    check("R2 user exclude present", {59'd0, ep, cp}, 64'd0);

    // R1: reset in the middle of a run
    drive(2'd0, 1'b0, wv, 32'h0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid-run reset permits", {59'd0, ep, cp}, 64'd0);
    check("R1 mid-run reset selectors", {48'd0, es}, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R8 after reset release", {48'd0, es}, {48'd0, exp_sel});

    finish_up();
  end
endmodule